// File: doc/BRIEF.md
# UART Receiver with Line Status Flags

This block receives asynchronous serial characters and holds the most recent one in a one-character receive buffer. Next to the buffer sits a line status register that the CPU can read. The serial input is first synchronized to the clock. It is then sampled on a tick that the baud-rate logic supplies at sixteen times the bit rate. The frame can be set to 5 to 8 data bits, no parity, even parity or odd parity, and one or two stop bits.

The CPU reaches the block through a register port with one address bit. Address 0 is the receive buffer and address 1 is the line status register. Each status flag has its own clear rule. Data-ready clears when the buffer is read, or when the CPU writes a 0 into that bit. The four error flags clear only when the status register is read. An interrupt request line is high while any error flag is set and the interrupt enable input is high.

Top module: `uart_rx_lsr`

## Requirements
- R1: When a character completes, data-ready is set and the receive buffer holds the data bits right-aligned. The first received bit is bit 0, and unused upper bits are 0. `cfg_data_bits` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R2: A read strobe at address 0 clears data-ready. A write at address 1 with `cpu_wdata[0]`=0 also clears it. A write at address 1 with `cpu_wdata[0]`=1 leaves it unchanged.
- R3: Overrun (status bit 1) is set when a new character is loaded while data-ready is still set and the buffer is not read in that cycle. The new character replaces the old one.
- R4: Parity error (status bit 2) is set when the parity bit does not match the selection. `cfg_parity_even`=1 means the data ones plus the parity bit give an even count, and 0 means an odd count. The check applies only when `cfg_parity_en`=1.
- R5: Framing error (status bit 3) is set when the first stop bit is sampled as 0. The receiver then waits for the line to return to 1 before it accepts a new start bit.
- R6: Break (status bit 4) is set once the input has stayed at 0 for more than a whole frame time (start, data, parity and stop bits, in 16x ticks). A break loads exactly one all-zero character.
- R7: A read strobe at address 1 clears status bits 1 to 4 and leaves data-ready as it is. A flag being set in the same cycle wins over the clear.
- R8: `irq_line_status` is high exactly when `ie_line_status` is 1 and at least one of status bits 1 to 4 is set.
- R9: Status bits 5, 6 and 7 always read 0. Bit 0 is data-ready, and bits 1 to 4 are overrun, parity, framing and break.
- R10: A start bit is confirmed on the 8th oversample tick after the low level is first seen. If the line is back at 1 at that point, the receiver returns to idle and loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_data_bits | input | 2 | Data bit count minus 5 |
| cfg_parity_en | input | 1 | Parity bit present |
| cfg_parity_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_two_stop | input | 1 | Two stop bits (affects the break frame time) |
| ie_line_status | input | 1 | Line status interrupt enable |
| cpu_addr | input | 1 | 0 = receive buffer, 1 = line status |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register |
| irq_line_status | output | 1 | Receiver line status interrupt request |

## Verification
The assertions take some things about the inputs for granted:
- `os_tick` is a single-cycle pulse.
- The frame configuration does not change while a character is being received.
- A read strobe lasts exactly one clock per access.

The bench holds the configuration still between frames and drives every serial bit for exactly sixteen ticks. It issues each strobe for one cycle, between clock edges. Break and false-start stimulus change the line only on tick boundaries, so the sample points fall clearly inside each level.

// File: rtl/uart_rx_pkg.sv
// Shared constants and types for the UART receiver.
// Assumes a data path of at most 8 bits and a minimum character of 5 bits.
package uart_rx_pkg;
    localparam int DATA_W   = 8;
    localparam int MIN_BITS = 5;
    localparam int CFG_W    = $clog2(DATA_W - MIN_BITS + 1);

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP, RX_WAIT_HIGH
    } rx_state_e;

    // Line status flags; packed so that dr lands on bit 0 and brk on bit 4.
    typedef struct packed {
        logic brk;
        logic fe;
        logic pe;
        logic oe;
        logic dr;
    } lsr_bits_t;
endpackage

// File: rtl/rx_sync.sv
// Multi-flop synchronizer for the asynchronous serial input.
// Resets to the idle (high) line level.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
// Frame sampler: finds the start bit, samples each bit at mid-bit on the
// oversample tick and delivers one character with its parity and framing
// result. Assumes the configuration stays still while a frame is received.
module rx_frame_engine
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic [CFG_W-1:0]  cfg_bits,
    input  logic              par_en,
    input  logic              par_even,
    output logic              load_evt,
    output logic [DATA_W-1:0] load_data,
    output logic              load_pe,
    output logic              load_fe
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_acc_q;
    logic              par_bad_q;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  align_sh;
    logic [DATA_W-1:0] aligned;
    logic              par_mismatch;

    // Derive the last bit index, the alignment shift and the parity outcome.
    always_comb begin
        last_idx     = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_bits);
        align_sh     = IDX_W'(DATA_W - MIN_BITS) - IDX_W'(cfg_bits);
        aligned      = shreg_q >> align_sh;
        par_mismatch = par_even ? (par_acc_q ^ rxd_s) : ~(par_acc_q ^ rxd_s);
    end

    // Receive state machine, advanced on each oversample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RX_IDLE;
            cnt_q     <= '0;
            idx_q     <= '0;
            shreg_q   <= '0;
            par_acc_q <= 1'b0;
            par_bad_q <= 1'b0;
            load_evt  <= 1'b0;
            load_data <= '0;
            load_pe   <= 1'b0;
            load_fe   <= 1'b0;
        end else begin
            load_evt <= 1'b0;
            if (tick) begin
                unique case (state_q)
                    RX_IDLE: begin
                        if (!rxd_s) begin
                            state_q <= RX_START;
                            cnt_q   <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt_q == MID) begin
                            cnt_q <= '0;
                            if (rxd_s) begin
                                state_q <= RX_IDLE;
                            end else begin
                                state_q   <= RX_DATA;
                                idx_q     <= '0;
                                par_acc_q <= 1'b0;
                                par_bad_q <= 1'b0;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            shreg_q   <= {rxd_s, shreg_q[DATA_W-1:1]};
                            par_acc_q <= par_acc_q ^ rxd_s;
                            if (idx_q == last_idx) state_q <= par_en ? RX_PARITY : RX_STOP;
                            else                   idx_q   <= idx_q + 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            par_bad_q <= par_mismatch;
                            state_q   <= RX_STOP;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt_q == LAST) begin
                            cnt_q     <= '0;
                            load_evt  <= 1'b1;
                            load_data <= aligned;
                            load_pe   <= par_en & par_bad_q;
                            load_fe   <= ~rxd_s;
                            state_q   <= rxd_s ? RX_IDLE : RX_WAIT_HIGH;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    RX_WAIT_HIGH: begin
                        if (rxd_s) state_q <= RX_IDLE;
                    end
                    default: state_q <= RX_IDLE;
                endcase
            end
        end
    end

    AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_START && tick && cnt_q == MID && rxd_s) |=> (state_q == RX_IDLE && !load_evt)); // R10
    AST_NO_LOAD_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_WAIT_HIGH) |=> !load_evt); // R6
    AST_SINGLE_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> !load_evt); // R1
endmodule

// File: rtl/rx_break_timer.sv
// Break timer: counts oversample ticks while the line is low and pulses once
// when the low time exceeds one whole frame for the current configuration.
module rx_break_timer
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd_s,
    input  logic [CFG_W-1:0] cfg_bits,
    input  logic             par_en,
    input  logic             two_stop,
    output logic             brk_evt
);
    localparam int MAX_FRAME = OSR * (1 + DATA_W + 1 + 2);
    localparam int BRK_W     = $clog2(MAX_FRAME + 2);

    logic [BRK_W-1:0] cnt_q;
    logic [BRK_W-1:0] frame_len;

    // Frame time in ticks: start, data, optional parity, one or two stops.
    always_comb begin
        frame_len = BRK_W'(OSR) * (BRK_W'(MIN_BITS + 2) + BRK_W'(cfg_bits)
                                   + BRK_W'(par_en) + BRK_W'(two_stop));
    end

    // Count low ticks, saturating one past the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            brk_evt <= 1'b0;
        end else begin
            brk_evt <= 1'b0;
            if (rxd_s) begin
                cnt_q <= '0;
            end else if (tick && cnt_q <= frame_len) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == frame_len) brk_evt <= 1'b1;
            end
        end
    end

    AST_BRK_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |=> !brk_evt); // R6
    AST_BRK_PAST_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |-> (cnt_q == frame_len + 1'b1)); // R6
endmodule

// File: rtl/rx_status_regs.sv
// Receive buffer and line status flags with per-flag set and clear rules.
// A set event in a cycle wins over a clear in the same cycle.
module rx_status_regs
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_evt,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_pe,
    input  logic              load_fe,
    input  logic              brk_evt,
    input  logic              rd_buf,
    input  logic              rd_status,
    input  logic              wr_dr_zero,
    output logic [DATA_W-1:0] rbr,
    output lsr_bits_t         lsr
);
    logic oe_set;

    // Overrun: a new character arrives while the old one is still unread.
    always_comb oe_set = load_evt & lsr.dr & ~rd_buf;

    // Receive buffer: replaced on every delivered character.
    always_ff @(posedge clk) begin
        if (!rst_n)        rbr <= '0;
        else if (load_evt) rbr <= load_data;
    end

    // Data-ready: set on load, cleared by buffer read or a zero write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lsr.dr <= 1'b0;
        else if (load_evt)               lsr.dr <= 1'b1;
        else if (rd_buf || wr_dr_zero)   lsr.dr <= 1'b0;
    end

    // Error flags: sticky until the status register is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lsr.oe  <= 1'b0;
            lsr.pe  <= 1'b0;
            lsr.fe  <= 1'b0;
            lsr.brk <= 1'b0;
        end else begin
            lsr.oe  <= oe_set              | (lsr.oe  & ~rd_status);
            lsr.pe  <= (load_evt & load_pe) | (lsr.pe  & ~rd_status);
            lsr.fe  <= (load_evt & load_fe) | (lsr.fe  & ~rd_status);
            lsr.brk <= brk_evt             | (lsr.brk & ~rd_status);
        end
    end

    AST_DR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> lsr.dr); // R1
    AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_evt |=> $stable(rbr)); // R1
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (load_evt && lsr.dr && !rd_buf) |=> lsr.oe); // R3
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !load_evt && !brk_evt) |=> (!lsr.oe && !lsr.pe && !lsr.fe && !lsr.brk)); // R7
    AST_DR_KEPT_ON_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !rd_buf && !wr_dr_zero && lsr.dr) |=> lsr.dr); // R7
endmodule

// File: rtl/uart_rx_lsr.sv
// Top of the UART receiver: synchronizer, frame sampler, break timer and
// status registers behind a one-bit-address register port.
// Assumes os_tick pulses for one clock at 16x the bit rate.
module uart_rx_lsr
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             rxd,
    input  logic [CFG_W-1:0] cfg_data_bits,
    input  logic             cfg_parity_en,
    input  logic             cfg_parity_even,
    input  logic             cfg_two_stop,
    input  logic             ie_line_status,
    input  logic             cpu_addr,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic             irq_line_status
);
    logic              rxd_s;
    logic              load_evt;
    logic [DATA_W-1:0] load_data;
    logic              load_pe;
    logic              load_fe;
    logic              brk_evt;
    logic [DATA_W-1:0] rbr;
    lsr_bits_t         lsr;
    logic              rd_buf;
    logic              rd_status;
    logic              wr_dr_zero;

    // Decode CPU strobes into per-register events.
    always_comb begin
        rd_buf     = cpu_rd & ~cpu_addr;
        rd_status  = cpu_rd &  cpu_addr;
        wr_dr_zero = cpu_wr &  cpu_addr & ~cpu_wdata[0];
    end

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxd_s)
    );

    rx_frame_engine #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd_s(rxd_s),
        .cfg_bits(cfg_data_bits), .par_en(cfg_parity_en), .par_even(cfg_parity_even),
        .load_evt(load_evt), .load_data(load_data), .load_pe(load_pe), .load_fe(load_fe)
    );

    rx_break_timer #(.OSR(OSR)) u_break (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd_s(rxd_s),
        .cfg_bits(cfg_data_bits), .par_en(cfg_parity_en), .two_stop(cfg_two_stop),
        .brk_evt(brk_evt)
    );

    rx_status_regs u_status (
        .clk(clk), .rst_n(rst_n), .load_evt(load_evt), .load_data(load_data),
        .load_pe(load_pe), .load_fe(load_fe), .brk_evt(brk_evt),
        .rd_buf(rd_buf), .rd_status(rd_status), .wr_dr_zero(wr_dr_zero),
        .rbr(rbr), .lsr(lsr)
    );

    // Register read mux; the upper status bits are tied low.
    always_comb begin
        if (cpu_addr) cpu_rdata = {3'b000, lsr};
        else          cpu_rdata = 8'(rbr);
    end

    // Interrupt request from any enabled receive error.
    always_comb irq_line_status = ie_line_status & (lsr.oe | lsr.pe | lsr.fe | lsr.brk);

    AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_line_status && $past(ie_line_status) && brk_evt) |=> irq_line_status); // R8
    AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr |-> (cpu_rdata[7:5] == 3'b000)); // R9
endmodule

// File: tb/uart_rx_lsr_bench.sv
module uart_rx_lsr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_data_bits = 2'd3;
    logic       cfg_parity_en = 1'b0;
    logic       cfg_parity_even = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       ie_line_status = 1'b0;
    logic       cpu_addr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       irq_line_status;

    int checks = 0;
    int failures = 0;
    logic [7:0] v;
    int tdiv = 0;

    always #2 clk = ~clk;

    // Tick generator: one pulse every 4 clocks.
    always @(posedge clk) begin
        tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
        os_tick <= (tdiv == 3);
    end

    uart_rx_lsr u_uart_rx_lsr (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_data_bits(cfg_data_bits), .cfg_parity_en(cfg_parity_en),
        .cfg_parity_even(cfg_parity_even), .cfg_two_stop(cfg_two_stop),
        .ie_line_status(ie_line_status), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_line_status(irq_line_status)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic a, output logic [7:0] val);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 val = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic peek(input logic a, output logic [7:0] val);
        @(negedge clk);
        cpu_addr = a;
        #1 val = cpu_rdata;
    endtask

    task automatic wr_status(input logic [7:0] d);
        @(negedge clk);
        cpu_addr = 1'b1; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic hold_line(input logic b, input int nticks);
        @(negedge clk);
        rxd = b;
        for (int i = 0; i < nticks; i++) begin
            @(posedge os_tick);
        end
    endtask

    // Send one frame with the current configuration; optional bad parity/stop.
    task automatic send_frame(input logic [7:0] d, input logic flip_par, input logic stop_val);
        int n;
        logic p;
        n = 5 + int'(cfg_data_bits);
        p = 1'b0;
        hold_line(1'b0, 16);
        for (int i = 0; i < n; i++) begin
            hold_line(d[i], 16);
            p = p ^ d[i];
        end
        if (cfg_parity_en) hold_line((cfg_parity_even ? p : ~p) ^ flip_par, 16);
        hold_line(stop_val, 16);
        hold_line(1'b1, 32);
    endtask

    task automatic t_reset;
        peek(1'b1, v); check("R9 reset status", v, 8'h00);
        check("R8 reset irq", {7'd0, irq_line_status}, 8'h00);
    endtask

    task automatic t_basic;
        cfg_data_bits = 2'd3; cfg_parity_en = 1'b0;
        send_frame(8'hA5, 1'b0, 1'b1);
        peek(1'b1, v); check("R1 dr after char", v, 8'h01);
        rd_reg(1'b0, v); check("R1 data 8 bits", v, 8'hA5);
        peek(1'b1, v); check("R2 dr cleared by buffer read", v, 8'h00);
    endtask

    task automatic t_short_even;
        cfg_data_bits = 2'd0; cfg_parity_en = 1'b1; cfg_parity_even = 1'b1;
        send_frame(8'hF5, 1'b0, 1'b1);
        peek(1'b1, v); check("R4 even parity good", v, 8'h01);
        rd_reg(1'b0, v); check("R1 data 5 bits aligned", v, 8'h15);
    endtask

    task automatic t_parity_err;
        cfg_data_bits = 2'd2; cfg_parity_en = 1'b1; cfg_parity_even = 1'b0;
        ie_line_status = 1'b1;
        send_frame(8'h3C, 1'b1, 1'b1);
        peek(1'b1, v); check("R8 irq on parity error", {7'd0, irq_line_status}, 8'h01);
        rd_reg(1'b1, v); check("R4 odd parity error", v, 8'h05);
        peek(1'b1, v); check("R7 status read keeps dr", v, 8'h01);
        check("R8 irq drops after clear", {7'd0, irq_line_status}, 8'h00);
        rd_reg(1'b0, v); check("R1 data 7 bits", v, 8'h3C);
        ie_line_status = 1'b0;
        send_frame(8'h11, 1'b1, 1'b1);
        check("R8 irq masked", {7'd0, irq_line_status}, 8'h00);
        rd_reg(1'b1, v); check("R4 parity error again", v, 8'h05);
        rd_reg(1'b0, v);
    endtask

    task automatic t_overrun;
        cfg_data_bits = 2'd3; cfg_parity_en = 1'b0;
        send_frame(8'h12, 1'b0, 1'b1);
        send_frame(8'h34, 1'b0, 1'b1);
        rd_reg(1'b1, v); check("R3 overrun flag", v, 8'h03);
        rd_reg(1'b0, v); check("R3 newest data kept", v, 8'h34);
        peek(1'b1, v); check("R7 overrun cleared", v, 8'h00);
    endtask

    task automatic t_framing;
        send_frame(8'h55, 1'b0, 1'b0);
        rd_reg(1'b1, v); check("R5 framing error", v, 8'h09);
        rd_reg(1'b0, v); check("R5 data with bad stop", v, 8'h55);
        send_frame(8'h66, 1'b0, 1'b1);
        rd_reg(1'b0, v); check("R5 receiver recovers", v, 8'h66);
    endtask

    task automatic t_write_zero;
        send_frame(8'h7E, 1'b0, 1'b1);
        wr_status(8'h01);
        peek(1'b1, v); check("R2 write one keeps dr", v, 8'h01);
        wr_status(8'h00);
        peek(1'b1, v); check("R2 write zero clears dr", v, 8'h00);
        peek(1'b0, v); check("R2 buffer untouched", v, 8'h7E);
    endtask

    task automatic t_false_start;
        hold_line(1'b0, 4);
        hold_line(1'b1, 48);
        peek(1'b1, v); check("R10 false start ignored", v, 8'h00);
        send_frame(8'hC3, 1'b0, 1'b1);
        rd_reg(1'b0, v); check("R10 next frame received", v, 8'hC3);
    endtask

    task automatic t_break;
        cfg_data_bits = 2'd3; cfg_parity_en = 1'b0; cfg_two_stop = 1'b0;
        ie_line_status = 1'b1;
        hold_line(1'b0, 224);
        hold_line(1'b1, 48);
        check("R8 irq on break", {7'd0, irq_line_status}, 8'h01);
        rd_reg(1'b1, v); check("R6 break single zero char", v, 8'h19);
        rd_reg(1'b0, v); check("R6 break data zero", v, 8'h00);
        peek(1'b1, v); check("R9 status after break cleared", v, 8'h00);
        ie_line_status = 1'b0;
        cfg_two_stop = 1'b1; cfg_parity_en = 1'b1;
        hold_line(1'b0, 176);
        hold_line(1'b1, 48);
        rd_reg(1'b1, v); check("R6 no break below frame time", v & 8'h10, 8'h00);
        rd_reg(1'b0, v);
        cfg_two_stop = 1'b0; cfg_parity_en = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_short_even();
        t_parity_err();
        t_overrun();
        t_framing();
        t_write_zero();
        t_false_start();
        t_break();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule